// File: doc/BRIEF.md
# Trimmable VLIW Register Crossbar Slice

This block is one slice of a wide-issue datapath. A register file with several read and write ports feeds three single-cycle functional units through an input crossbar. Each unit result goes back to the register file through an output crossbar. Every cycle a wide control word supplies:

- the register address for each read port,
- the read-port choice for each unit operand,
- the unit choice for each write port,
- a target register and an enable for each write port,
- an add/subtract choice for the middle unit.

Three compile-time bit masks say which links physically exist: register-to-read-port links, read-port-to-operand links and unit-to-write-port links. A mux with several links left is built over those inputs only. A mux with one link left becomes a plain wire. A select that names a missing link is treated as illegal and latches an error flag.

The intended use is to start from a fully connected slice and clear mask bits for links that a given program never uses. The same control word format is kept for every mask setting.

Top module: `trim_xbar_slice`

## Requirements
- R1: While reset (`rstN` low, asynchronous) is asserted, all registers clear to zero and `errFlag` is 0.
- R2: Read port p returns the register named by its address whenever RF_MASK bit p*NREG+r is set for that register r.
- R3: Operand o feeds unit o/2 (even o is the first operand, odd o is the second). It takes the read port p named by its select when IN_MASK bit o*NRD+p is set.
- R4: Write port w takes the result of unit f named by its source select when OUT_MASK bit w*NFU+f is set.
- R5: A mux with exactly one link left outputs that link whatever its select holds.
- R6: On a mux with two or more links left, a select naming a removed or nonexistent link drives zero on that path.
- R7: `errFlag` goes high on the clock edge after any illegal select and stays high until reset. Read-port and operand selects always count. A mux with one link counts any select other than its link.
- R8: Register writes take effect at the clock edge, and reads are combinational. A read of a register being written in the same cycle returns the old value.
- R9: When several enabled write ports target one register in a cycle, the lowest-numbered port's data is stored.
- R10: Unit 0 computes a+b. Unit 1 computes a-b when `fuSub` is 1 and a+b otherwise. Unit 2 computes the low DW bits of a*b. All wrap modulo 2^DW.
- R11: A write port with its enable low changes no register, and its source select is not checked for legality.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rdAddr | input | NRD*AW | Register address per read port, port p at bits p*AW |
| opSel | input | 6*PW | Read-port select per unit operand, operand o at bits o*PW |
| fuSub | input | 1 | Unit 1 subtracts when 1 |
| wrSrc | input | NWR*FW | Unit select per write port, port w at bits w*FW |
| wrAddr | input | NWR*AW | Target register per write port |
| wrEn | input | NWR | Write enable per write port |
| rdData | output | NRD*DW | Read port values |
| fuOut | output | 3*DW | Unit results, unit f at bits f*DW |
| errFlag | output | 1 | Sticky illegal-select flag |

## Verification
Writing a register and reading it through a read port can happen in the same cycle. Several write ports can also land on one register in the same cycle. The bench provokes both by drawing write addresses at random over only eight registers, and it adds directed cycles for each case.

A bench model applies the ports' writes only after it has evaluated the cycle's reads. It applies them from the highest port down, so the lowest port's data is the one left in the register. Every read port value is compared with that model.

An illegal select in the same cycle as a write is also exercised. Each one is judged by the zeroed path result and by the flag one edge later.

// File: rtl/vxs_pkg.sv
package vxs_pkg;
  localparam int NFU   = 3;
  localparam int NOPND = 2 * NFU;

  typedef struct packed {
    logic fuSub;
    logic rfWrite;
  } dpStrobe_t;

  function automatic int linkCount(input logic [63:0] m);
    int c = 0;
    for (int i = 0; i < 64; i++) if (m[i]) c++;
    return c;
  endfunction

  function automatic int firstLink(input logic [63:0] m);
    for (int i = 63; i >= 0; i--) if (m[i]) firstLink = i;
    if (m == 64'd0) firstLink = 0;
  endfunction
endpackage

// File: rtl/vxs_linkmux.sv
module vxs_linkmux
  import vxs_pkg::*;
#(
  parameter int N = 4,
  parameter int DW = 16,
  parameter logic [N-1:0] MASK = '1,
  parameter int SW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N*DW-1:0] inBus,
  input  logic [SW-1:0]   sel,
  output logic [DW-1:0]   dout,
  output logic            illegal
);
  localparam int LINKS = linkCount(64'(MASK));
  localparam int ONLY  = firstLink(64'(MASK));

  generate
    if (LINKS == 0) begin : g_none
      assign dout = '0;
      assign illegal = 1'b1;
    end else if (LINKS == 1) begin : g_wire
      assign dout = inBus[ONLY*DW +: DW];
      assign illegal = (sel != SW'(ONLY));
    end else begin : g_mux
      always_comb begin
        dout = '0;
        illegal = 1'b1;
        for (int i = 0; i < N; i++) begin
          if (MASK[i] && sel == SW'(i)) begin
            dout = inBus[i*DW +: DW];
            illegal = 1'b0;
          end
        end
      end
    end
  endgenerate
endmodule

// File: rtl/vxs_ctrl.sv
module vxs_ctrl
  import vxs_pkg::*;
#(
  parameter int NRD = 4,
  parameter int NWR = 3,
  parameter int AW = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NWR-1:0]   wrEn,
  input  logic [NWR*AW-1:0] wrAddr,
  input  logic             fuSubIn,
  input  logic [NRD-1:0]   illRd,
  input  logic [NOPND-1:0] illOp,
  input  logic [NWR-1:0]   illWr,
  output dpStrobe_t        strobe,
  output logic [NWR-1:0]   commit,
  output logic             errFlag
);
  logic errSet;

  assign errSet = (|illRd) | (|illOp) | (|(illWr & wrEn));

  always_comb begin
    for (int w = 0; w < NWR; w++) begin
      commit[w] = wrEn[w];
      for (int j = 0; j < w; j++) begin
        if (wrEn[j] && wrAddr[j*AW +: AW] == wrAddr[w*AW +: AW]) commit[w] = 1'b0;
      end
    end
  end

  assign strobe.fuSub   = fuSubIn;
  assign strobe.rfWrite = |commit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) errFlag <= 1'b0;
    else if (errSet) errFlag <= 1'b1;
  end

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);

  // R7
  err_raise_chk: assert property (@(posedge clk) disable iff (!rstN)
    errSet |=> errFlag);

  // R9
  generate
    for (genvar i = 0; i < NWR; i++) begin : g_pi
      for (genvar j = i + 1; j < NWR; j++) begin : g_pj
        one_winner_chk: assert property (@(posedge clk) disable iff (!rstN)
          (commit[i] && commit[j]) |-> (wrAddr[i*AW +: AW] != wrAddr[j*AW +: AW]));
      end
    end
  endgenerate
endmodule

// File: rtl/vxs_datapath.sv
module vxs_datapath
  import vxs_pkg::*;
#(
  parameter int NREG = 8,
  parameter int DW = 16,
  parameter int NRD = 4,
  parameter int NWR = 3,
  parameter int AW = 3,
  parameter int PW = 2,
  parameter int FW = 2,
  parameter logic [NRD*NREG-1:0]  RF_MASK  = '1,
  parameter logic [NOPND*NRD-1:0] IN_MASK  = '1,
  parameter logic [NWR*NFU-1:0]   OUT_MASK = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [NWR-1:0]    commit,
  input  logic [NRD*AW-1:0] rdAddr,
  input  logic [NOPND*PW-1:0] opSel,
  input  logic [NWR*FW-1:0] wrSrc,
  input  logic [NWR*AW-1:0] wrAddr,
  output logic [NRD*DW-1:0] rdData,
  output logic [NFU*DW-1:0] fuOut,
  output logic [NRD-1:0]    illRd,
  output logic [NOPND-1:0]  illOp,
  output logic [NWR-1:0]    illWr
);
  logic [DW-1:0] regs [NREG];
  logic [NREG*DW-1:0] regFlat;
  logic [DW-1:0] opnd [NOPND];
  logic [DW-1:0] wrData [NWR];

  always_comb begin
    for (int r = 0; r < NREG; r++) regFlat[r*DW +: DW] = regs[r];
  end

  generate
    for (genvar p = 0; p < NRD; p++) begin : g_rdport
      vxs_linkmux #(.N(NREG), .DW(DW), .MASK(RF_MASK[p*NREG +: NREG]), .SW(AW)) u_rd (
        .inBus(regFlat), .sel(rdAddr[p*AW +: AW]),
        .dout(rdData[p*DW +: DW]), .illegal(illRd[p]));
    end
    for (genvar o = 0; o < NOPND; o++) begin : g_opnd
      vxs_linkmux #(.N(NRD), .DW(DW), .MASK(IN_MASK[o*NRD +: NRD]), .SW(PW)) u_op (
        .inBus(rdData), .sel(opSel[o*PW +: PW]),
        .dout(opnd[o]), .illegal(illOp[o]));
    end
    for (genvar w = 0; w < NWR; w++) begin : g_wrport
      vxs_linkmux #(.N(NFU), .DW(DW), .MASK(OUT_MASK[w*NFU +: NFU]), .SW(FW)) u_wr (
        .inBus(fuOut), .sel(wrSrc[w*FW +: FW]),
        .dout(wrData[w]), .illegal(illWr[w]));
    end
  endgenerate

  always_comb begin
    fuOut[0 +: DW]    = opnd[0] + opnd[1];
    fuOut[DW +: DW]   = strobe.fuSub ? (opnd[2] - opnd[3]) : (opnd[2] + opnd[3]);
    fuOut[2*DW +: DW] = opnd[4] * opnd[5];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < NREG; r++) regs[r] <= '0;
    end else if (strobe.rfWrite) begin
      for (int w = 0; w < NWR; w++) begin
        if (commit[w]) regs[wrAddr[w*AW +: AW]] <= wrData[w];
      end
    end
  end

  generate
    for (genvar p = 0; p < NRD; p++) begin : g_rdchk
      // R2
      rd_match_chk: assert property (@(posedge clk) disable iff (!rstN)
        !illRd[p] |-> (rdData[p*DW +: DW] == regs[rdAddr[p*AW +: AW]]));
    end
    for (genvar w = 0; w < NWR; w++) begin : g_wrchk
      // R8
      wr_land_chk: assert property (@(posedge clk) disable iff (!rstN)
        commit[w] |=> (regs[$past(wrAddr[w*AW +: AW])] == $past(wrData[w])));
    end
  endgenerate
endmodule

// File: rtl/trim_xbar_slice.sv
module trim_xbar_slice
  import vxs_pkg::*;
#(
  parameter int NREG = 8,
  parameter int DW = 16,
  parameter int NRD = 4,
  parameter int NWR = 3,
  parameter logic [NRD*NREG-1:0]  RF_MASK  = '1,
  parameter logic [NOPND*NRD-1:0] IN_MASK  = '1,
  parameter logic [NWR*NFU-1:0]   OUT_MASK = '1,
  localparam int AW = $clog2(NREG),
  localparam int PW = $clog2(NRD),
  localparam int FW = $clog2(NFU)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NRD*AW-1:0]   rdAddr,
  input  logic [NOPND*PW-1:0] opSel,
  input  logic                fuSub,
  input  logic [NWR*FW-1:0]   wrSrc,
  input  logic [NWR*AW-1:0]   wrAddr,
  input  logic [NWR-1:0]      wrEn,
  output logic [NRD*DW-1:0]   rdData,
  output logic [NFU*DW-1:0]   fuOut,
  output logic                errFlag
);
  dpStrobe_t strobe;
  logic [NWR-1:0]   commit;
  logic [NRD-1:0]   illRd;
  logic [NOPND-1:0] illOp;
  logic [NWR-1:0]   illWr;

  vxs_ctrl #(.NRD(NRD), .NWR(NWR), .AW(AW)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .fuSubIn(fuSub),
    .illRd(illRd), .illOp(illOp), .illWr(illWr),
    .strobe(strobe), .commit(commit), .errFlag(errFlag));

  vxs_datapath #(.NREG(NREG), .DW(DW), .NRD(NRD), .NWR(NWR), .AW(AW), .PW(PW), .FW(FW),
    .RF_MASK(RF_MASK), .IN_MASK(IN_MASK), .OUT_MASK(OUT_MASK)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .commit(commit),
    .rdAddr(rdAddr), .opSel(opSel), .wrSrc(wrSrc), .wrAddr(wrAddr),
    .rdData(rdData), .fuOut(fuOut), .illRd(illRd), .illOp(illOp), .illWr(illWr));
endmodule

// File: tb/sim_trim_xbar_slice.sv
module sim_trim_xbar_slice;
  localparam int CLK_NS = 10;
  localparam int NREG = 8, DW = 16, NRD = 4, NWR = 3, NFU = 3, NOP = 6;
  localparam int AW = 3, PW = 2, FW = 2;
  // port3 -> reg5 only (wire), port2 -> regs 0..3, ports 0/1 -> all
  localparam logic [31:0] RFM  = 32'h200F_FFFF;
  // op5:{p0,p2} op4:all op3:p3 wire op2:{p0,p1} op1:all op0:all
  localparam logic [23:0] INM  = 24'h5F83FF;
  // wp2:{fu1,fu2} wp1:fu0 wire wp0:all
  localparam logic [8:0]  OUTM = 9'b110_001_111;

  logic clk = 0, rstN = 0;
  logic [NRD*AW-1:0] rdAddr = '0;
  logic [NOP*PW-1:0] opSel = '0;
  logic fuSub = 0;
  logic [NWR*FW-1:0] wrSrc = '0;
  logic [NWR*AW-1:0] wrAddr = '0;
  logic [NWR-1:0] wrEn = '0;
  logic [NRD*DW-1:0] rdData;
  logic [NFU*DW-1:0] fuOut;
  logic errFlag;

  int total = 0, bad = 0;
  logic [DW-1:0] mReg [NREG];
  logic mErr = 0;
  logic [DW-1:0] expRd [NRD];
  logic [DW-1:0] expFu [NFU];
  logic [DW-1:0] expWd [NWR];
  logic [DW-1:0] op [NOP];
  logic illAny;

  always #(CLK_NS/2) clk = ~clk;

  trim_xbar_slice #(.NREG(NREG), .DW(DW), .NRD(NRD), .NWR(NWR),
    .RF_MASK(RFM), .IN_MASK(INM), .OUT_MASK(OUTM)) u0 (
    .clk(clk), .rstN(rstN), .rdAddr(rdAddr), .opSel(opSel), .fuSub(fuSub),
    .wrSrc(wrSrc), .wrAddr(wrAddr), .wrEn(wrEn),
    .rdData(rdData), .fuOut(fuOut), .errFlag(errFlag));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R5 R6: reference link mux
  function automatic logic [DW-1:0] refMux(input logic [7:0] mask, input int n, input int sel,
                                           input logic [DW-1:0] ins [8], output logic ill);
    int cnt = 0, only = 0;
    for (int i = n - 1; i >= 0; i--) if (mask[i]) begin cnt++; only = i; end
    if (cnt == 0) begin ill = 1; return '0; end
    if (cnt == 1) begin ill = (sel != only); return ins[only]; end
    ill = !(sel < n && mask[sel]);
    return ill ? '0 : ins[sel];
  endfunction

  task automatic evaluate();
    logic [DW-1:0] ins [8];
    logic ill;
    illAny = 0;
    for (int p = 0; p < NRD; p++) begin
      for (int r = 0; r < 8; r++) ins[r] = mReg[r];
      expRd[p] = refMux(RFM[p*8 +: 8], NREG, int'(rdAddr[p*AW +: AW]), ins, ill);
      illAny |= ill;
    end
    for (int o = 0; o < NOP; o++) begin
      for (int r = 0; r < 8; r++) ins[r] = (r < NRD) ? expRd[r] : '0;
      op[o] = refMux({4'b0, INM[o*4 +: 4]}, NRD, int'(opSel[o*PW +: PW]), ins, ill);
      illAny |= ill;
    end
    // R10
    expFu[0] = op[0] + op[1];
    expFu[1] = fuSub ? op[2] - op[3] : op[2] + op[3];
    expFu[2] = op[4] * op[5];
    for (int w = 0; w < NWR; w++) begin
      for (int r = 0; r < 8; r++) ins[r] = (r < NFU) ? expFu[r] : '0;
      expWd[w] = refMux({5'b0, OUTM[w*3 +: 3]}, NFU, int'(wrSrc[w*FW +: FW]), ins, ill);
      if (wrEn[w]) illAny |= ill; // R11: disabled ports unchecked
    end
  endtask

  task automatic settle();
    #1;
    evaluate();
    for (int p = 0; p < NRD; p++) chk($sformatf("R2 R4 R8 rdData[%0d]", p), 32'(rdData[p*DW +: DW]), 32'(expRd[p]));
    for (int f = 0; f < NFU; f++) chk($sformatf("R3 R10 fuOut[%0d]", f), 32'(fuOut[f*DW +: DW]), 32'(expFu[f]));
    chk("R7 errFlag", 32'(errFlag), 32'(mErr));
  endtask

  task automatic advance();
    @(posedge clk);
    // R9: highest port first so the lowest ends on top
    for (int w = NWR - 1; w >= 0; w--) if (wrEn[w]) mReg[wrAddr[w*AW +: AW]] = expWd[w];
    mErr |= illAny;
    @(negedge clk);
  endtask

  function automatic int pick(input logic [7:0] mask, input int n);
    int v;
    do v = $urandom_range(n - 1); while (!mask[v]);
    return v;
  endfunction

  task automatic randLegal();
    for (int p = 0; p < NRD; p++) rdAddr[p*AW +: AW] = AW'(pick(RFM[p*8 +: 8], NREG));
    for (int o = 0; o < NOP; o++) opSel[o*PW +: PW] = PW'(pick({4'b0, INM[o*4 +: 4]}, NRD));
    for (int w = 0; w < NWR; w++) begin
      wrSrc[w*FW +: FW] = FW'(pick({5'b0, OUTM[w*3 +: 3]}, NFU));
      wrAddr[w*AW +: AW] = AW'($urandom_range(NREG - 1));
    end
    wrEn = NWR'($urandom_range(7));
    fuSub = 1'($urandom_range(1));
  endtask

  initial begin
    #(CLK_NS * 200000);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] keep;
    void'($urandom(32'd4242));
    for (int r = 0; r < NREG; r++) mReg[r] = '0;
    repeat (2) @(negedge clk);
    // R1: reset state
    for (int a = 0; a < NREG; a++) begin
      rdAddr[0 +: AW] = AW'(a);
      #1;
      chk("R1 reg after reset", 32'(rdData[0 +: DW]), 32'd0);
    end
    chk("R1 errFlag in reset", 32'(errFlag), 32'd0);
    rstN = 1;
    @(negedge clk);

    // random legal traffic, collisions and same-cycle read/write arise often
    for (int k = 0; k < 400; k++) begin
      randLegal();
      settle();
      advance();
    end

    // R11: disabled port with illegal source
    randLegal();
    wrEn = 3'b000;
    wrSrc[1*FW +: FW] = 2'd2;
    settle();
    advance();
    settle();
    chk("R11 no flag from disabled port", 32'(errFlag), 32'd0);
    advance();

    // R9: all ports to reg4, port 0 must win
    randLegal();
    wrAddr = {3'd4, 3'd4, 3'd4};
    wrSrc = {2'd2, 2'd0, 2'd0};
    wrEn = 3'b111;
    fuSub = 1;
    settle();
    keep = expFu[0];
    advance();
    randLegal();
    wrEn = 0;
    rdAddr[0 +: AW] = 3'd4;
    settle();
    chk("R9 lowest port wins", 32'(rdData[0 +: DW]), 32'(keep));
    chk("R8 write visible next cycle", 32'(rdData[0 +: DW]), 32'(mReg[4]));
    advance();

    // R8: same-cycle read returns old value
    randLegal();
    rdAddr[0 +: AW] = 3'd3;
    wrAddr[0 +: AW] = 3'd3;
    wrSrc[0 +: FW] = 2'd0;
    wrEn = 3'b001;
    settle();
    chk("R8 old value read", 32'(rdData[0 +: DW]), 32'(mReg[3]));
    advance();

    // R6: out-of-range source on enabled port writes zero
    randLegal();
    wrEn = 3'b001;
    wrAddr[0 +: AW] = 3'd1;
    wrSrc[0 +: FW] = 2'd3;
    settle();
    advance();
    randLegal();
    wrEn = 0;
    rdAddr[0 +: AW] = 3'd1;
    settle();
    chk("R6 zero written from illegal source", 32'(rdData[0 +: DW]), 32'd0);
    chk("R7 flag after illegal source", 32'(errFlag), 32'd1);
    advance();

    // R6: removed operand link gives zero operand
    randLegal();
    wrEn = 0;
    fuSub = 1;
    opSel[2*PW +: PW] = 2'd2;
    settle();
    chk("R6 zero operand into unit 1", 32'(fuOut[DW +: DW]), 32'(DW'(0) - expRd[3]));
    advance();

    // R5: single-link read port ignores its address
    randLegal();
    wrEn = 0;
    rdAddr[3*AW +: AW] = 3'd0;
    settle();
    chk("R5 wire port reads reg5", 32'(rdData[3*DW +: DW]), 32'(mReg[5]));
    advance();

    // R7: flag stays high through legal cycles
    for (int k = 0; k < 20; k++) begin
      randLegal();
      settle();
      advance();
    end
    chk("R7 flag sticky", 32'(errFlag), 32'd1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule